// File: doc/BRIEF.md
# Network Controller Suspend Sequencer

This block decides when a DMA-based network controller may stop moving frames after software asks it to suspend, and when it may start again. Software writes a suspend-request level. The sequencer closes the doors to new work at once: no new receive frame is admitted and no new transmit descriptor is fetched. It then waits for work already under way to finish. In the normal (slow) mode it also waits for every transmit and receive FIFO, and for both halves of the local buffer memory, to drain before it reports that the controller is suspended. In fast mode it reports suspension as soon as the active transfers end and leaves the buffered data where it is.

The block keeps the transmit and receive descriptor ring indices. The DMA engines advance these indices with one-cycle pulses. Dropping the suspend request returns the controller to normal operation at the same ring positions, with no re-initialisation. A hard reset, a soft reset or a stop command clears the indices and parks the block in a stopped state until software signals that initialisation is complete.

The states are STOPPED, RUN, DRAIN_ACTIVE, DRAIN_BUFFERS and SUSPENDED. These are the transitions:
- STOPPED→RUN on init done.
- RUN→DRAIN_ACTIVE on request.
- DRAIN_ACTIVE→SUSPENDED (fast mode) or DRAIN_ACTIVE→DRAIN_BUFFERS (slow mode) once both active-transfer flags are clear.
- DRAIN_BUFFERS→SUSPENDED once all four buffer-empty flags are set.
- DRAIN_ACTIVE, DRAIN_BUFFERS or SUSPENDED→RUN when the request is withdrawn.
- Any state→STOPPED on soft reset or stop.

Top module: `nc_suspend_seq`

## Requirements
- R1: After reset `state_o` is 0 (STOPPED), with `susp_status`, `rx_accept_en` and `tx_fetch_en` all 0. The block stays there until `init_done` is seen. It then enters RUN (`state_o`=1) on the next cycle, and both enables read 1.
- R2: In RUN, a high `suspend_req` moves the block to DRAIN_ACTIVE (`state_o`=2) on the next clock edge. From that edge on, `rx_accept_en` and `tx_fetch_en` are 0 in every state other than RUN.
- R3: DRAIN_ACTIVE is held for as long as `tx_dma_busy` or `rx_frame_busy` is high.
- R4: With `fast_en` low, DRAIN_ACTIVE moves to DRAIN_BUFFERS (`state_o`=3) on the edge after both busy flags are low. DRAIN_BUFFERS moves to SUSPENDED (`state_o`=4) only on the edge after all four empty flags (`tx_fifo_empty`, `rx_fifo_empty`, `lbm_tx_empty`, `lbm_rx_empty`) are high together.
- R5: With `fast_en` high, DRAIN_ACTIVE moves directly to SUSPENDED once both busy flags are low, whatever the empty flags are.
- R6: `susp_status` reads 1 only in SUSPENDED. It reads 0 in both drain states.
- R7: Withdrawing `suspend_req` in DRAIN_ACTIVE, DRAIN_BUFFERS or SUSPENDED returns the block to RUN on the next edge. `tx_idx` and `rx_idx` keep their values.
- R8: Each cycle with `tx_adv` (or `rx_adv`) high advances `tx_idx` (or `rx_idx`) by one in RUN and in the drain states. The index wraps to 0 after ring length − 1. The pulses are ignored in SUSPENDED and STOPPED.
- R9: A high `soft_rst` or `stop_req` puts the block in STOPPED with both indices 0 on the next edge. It stays in STOPPED until `init_done`, even after the request is withdrawn.
- R10: Asserting `rst_n` low clears the indices to 0 and forces STOPPED, whatever state the block was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst | input | 1 | Soft reset request |
| stop_req | input | 1 | Stop command |
| init_done | input | 1 | Initialisation finished, leaves STOPPED |
| suspend_req | input | 1 | Software suspend request level |
| fast_en | input | 1 | Fast suspend: skip buffer draining |
| tx_dma_busy | input | 1 | Transmit frame DMA in progress |
| rx_frame_busy | input | 1 | Receive frame in progress |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no frame |
| rx_fifo_empty | input | 1 | Receive FIFO holds no frame |
| lbm_tx_empty | input | 1 | Transmit area of local buffer memory empty |
| lbm_rx_empty | input | 1 | Receive area of local buffer memory empty |
| tx_adv | input | 1 | Transmit ring index advance pulse |
| rx_adv | input | 1 | Receive ring index advance pulse |
| rx_accept_en | output | 1 | New receive frames may be accepted |
| tx_fetch_en | output | 1 | New transmit descriptors may be fetched |
| susp_status | output | 1 | Suspend bit as read back by software |
| state_o | output | 3 | Current state code |
| tx_idx | output | clog2(TX_RING_LEN) | Transmit ring index |
| rx_idx | output | clog2(RX_RING_LEN) | Receive ring index |

## Verification
The drain logic is driven with both busy flags high, and the flags are then released one at a time. This separates a design that waits on their OR from one that waits on only one of them. The empty flags are set three at a time before the fourth. This catches a sequencer that ignores the receive half of the local buffer memory. The same request is repeated with fast mode on and all buffers non-empty, to show that the fast path really skips buffer draining. The request is also withdrawn in each drain state, and stop, soft reset and hard reset are applied with non-zero indices. Together these show that resume keeps the ring positions and that the three resets clear them.

// File: rtl/nc_susp_pkg.sv
package nc_susp_pkg;
    typedef enum logic [2:0] {
        ST_STOPPED       = 3'd0,
        ST_RUN           = 3'd1,
        ST_DRAIN_ACTIVE  = 3'd2,
        ST_DRAIN_BUFFERS = 3'd3,
        ST_SUSPENDED     = 3'd4
    } susp_state_t;
endpackage

// File: rtl/susp_drain_monitor.sv
module susp_drain_monitor #(
    parameter bit HAS_LBM = 1'b1
) (
    input  logic tx_dma_busy,
    input  logic rx_frame_busy,
    input  logic tx_fifo_empty,
    input  logic rx_fifo_empty,
    input  logic lbm_tx_empty,
    input  logic lbm_rx_empty,
    output logic active_idle,
    output logic buffers_empty
);
    logic lbm_clear;

    generate
        if (HAS_LBM) begin : g_lbm
            assign lbm_clear = lbm_tx_empty & lbm_rx_empty;
        end else begin : g_no_lbm
            // Without local buffer memory its flags never hold the drain.
            assign lbm_clear = 1'b1 | (lbm_tx_empty & lbm_rx_empty);
        end
    endgenerate

    assign active_idle   = ~tx_dma_busy & ~rx_frame_busy;
    assign buffers_empty = tx_fifo_empty & rx_fifo_empty & lbm_clear;
endmodule

// File: rtl/susp_fsm.sv
module susp_fsm
    import nc_susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        stop_req,
    input  logic        init_done,
    input  logic        suspend_req,
    input  logic        fast_en,
    input  logic        active_idle,
    input  logic        buffers_empty,
    output susp_state_t state,
    output logic        rx_accept_en,
    output logic        tx_fetch_en,
    output logic        susp_status,
    output logic        idx_run,
    output logic        idx_clr
);
    susp_state_t nxt;

    always_comb begin
        nxt = state;
        if (soft_rst || stop_req) begin
            nxt = ST_STOPPED;
        end else begin
            unique case (state)
                ST_STOPPED:       if (init_done) nxt = ST_RUN;
                ST_RUN:           if (suspend_req) nxt = ST_DRAIN_ACTIVE;
                ST_DRAIN_ACTIVE: begin
                    if (!suspend_req)     nxt = ST_RUN;
                    else if (active_idle) nxt = fast_en ? ST_SUSPENDED : ST_DRAIN_BUFFERS;
                end
                ST_DRAIN_BUFFERS: begin
                    if (!suspend_req)       nxt = ST_RUN;
                    else if (buffers_empty) nxt = ST_SUSPENDED;
                end
                ST_SUSPENDED:     if (!suspend_req) nxt = ST_RUN;
                default:          nxt = ST_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= nxt;
    end

    always_comb begin
        rx_accept_en = 1'b0;
        tx_fetch_en  = 1'b0;
        susp_status  = 1'b0;
        idx_run      = 1'b0;
        idx_clr      = soft_rst | stop_req;
        unique case (state)
            ST_STOPPED:       idx_clr = 1'b1;
            ST_RUN: begin
                rx_accept_en = 1'b1;
                tx_fetch_en  = 1'b1;
                idx_run      = 1'b1;
            end
            ST_DRAIN_ACTIVE:  idx_run = 1'b1;
            ST_DRAIN_BUFFERS: idx_run = 1'b1;
            ST_SUSPENDED:     susp_status = 1'b1;
            default:          idx_clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/ring_index_keeper.sv
module ring_index_keeper #(
    parameter int RING_LEN = 16,
    localparam int W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         adv,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] LAST = W'(RING_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              idx <= '0;
        else if (clr)            idx <= '0;
        else if (run && adv)     idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/nc_suspend_seq.sv
module nc_suspend_seq
    import nc_susp_pkg::*;
#(
    parameter int TX_RING_LEN = 16,
    parameter int RX_RING_LEN = 16,
    parameter bit HAS_LBM     = 1'b1,
    localparam int TXW = (TX_RING_LEN > 1) ? $clog2(TX_RING_LEN) : 1,
    localparam int RXW = (RX_RING_LEN > 1) ? $clog2(RX_RING_LEN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic           stop_req,
    input  logic           init_done,
    input  logic           suspend_req,
    input  logic           fast_en,
    input  logic           tx_dma_busy,
    input  logic           rx_frame_busy,
    input  logic           tx_fifo_empty,
    input  logic           rx_fifo_empty,
    input  logic           lbm_tx_empty,
    input  logic           lbm_rx_empty,
    input  logic           tx_adv,
    input  logic           rx_adv,
    output logic           rx_accept_en,
    output logic           tx_fetch_en,
    output logic           susp_status,
    output logic [2:0]     state_o,
    output logic [TXW-1:0] tx_idx,
    output logic [RXW-1:0] rx_idx
);
    logic        active_idle, buffers_empty, idx_run, idx_clr;
    susp_state_t state;

    susp_drain_monitor #(.HAS_LBM(HAS_LBM)) u_mon (
        .tx_dma_busy  (tx_dma_busy),
        .rx_frame_busy(rx_frame_busy),
        .tx_fifo_empty(tx_fifo_empty),
        .rx_fifo_empty(rx_fifo_empty),
        .lbm_tx_empty (lbm_tx_empty),
        .lbm_rx_empty (lbm_rx_empty),
        .active_idle  (active_idle),
        .buffers_empty(buffers_empty)
    );

    susp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .stop_req     (stop_req),
        .init_done    (init_done),
        .suspend_req  (suspend_req),
        .fast_en      (fast_en),
        .active_idle  (active_idle),
        .buffers_empty(buffers_empty),
        .state        (state),
        .rx_accept_en (rx_accept_en),
        .tx_fetch_en  (tx_fetch_en),
        .susp_status  (susp_status),
        .idx_run      (idx_run),
        .idx_clr      (idx_clr)
    );

    ring_index_keeper #(.RING_LEN(TX_RING_LEN)) u_tx_ring (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr), .run(idx_run), .adv(tx_adv), .idx(tx_idx)
    );

    ring_index_keeper #(.RING_LEN(RX_RING_LEN)) u_rx_ring (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr), .run(idx_run), .adv(rx_adv), .idx(rx_idx)
    );

    assign state_o = state;
endmodule

// File: rtl/nc_suspend_checker.sv
module nc_suspend_checker #(
    parameter int TXW = 4,
    parameter int RXW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           soft_rst,
    input logic           stop_req,
    input logic           suspend_req,
    input logic           fast_en,
    input logic           tx_dma_busy,
    input logic           rx_frame_busy,
    input logic           tx_fifo_empty,
    input logic           rx_fifo_empty,
    input logic           lbm_tx_empty,
    input logic           lbm_rx_empty,
    input logic           rx_accept_en,
    input logic           susp_status,
    input logic [2:0]     state_o,
    input logic [TXW-1:0] tx_idx,
    input logic [RXW-1:0] rx_idx
);
    p_no_accept_when_suspended_r2: assert property (@(posedge clk) disable iff (!rst_n)
        susp_status |-> !rx_accept_en);

    p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && (tx_dma_busy || rx_frame_busy) && suspend_req && !stop_req && !soft_rst)
        |=> state_o == 3'd2);

    p_slow_needs_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(susp_status) && !$past(fast_en))
        |-> $past(tx_fifo_empty && rx_fifo_empty && lbm_tx_empty && lbm_rx_empty));

    p_fast_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && fast_en && !tx_dma_busy && !rx_frame_busy && suspend_req
         && !stop_req && !soft_rst) |=> susp_status);

    p_withdraw_clears_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend_req |=> !susp_status);

    p_idx_frozen_suspended_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_status && $past(susp_status)) |-> ($stable(tx_idx) && $stable(rx_idx)));

    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || soft_rst) |=> (state_o == 3'd0 && tx_idx == '0 && rx_idx == '0));
endmodule

bind nc_suspend_seq nc_suspend_checker #(.TXW(TXW), .RXW(RXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_req(stop_req),
    .suspend_req(suspend_req), .fast_en(fast_en), .tx_dma_busy(tx_dma_busy),
    .rx_frame_busy(rx_frame_busy), .tx_fifo_empty(tx_fifo_empty),
    .rx_fifo_empty(rx_fifo_empty), .lbm_tx_empty(lbm_tx_empty),
    .lbm_rx_empty(lbm_rx_empty), .rx_accept_en(rx_accept_en),
    .susp_status(susp_status), .state_o(state_o), .tx_idx(tx_idx), .rx_idx(rx_idx)
);

// File: tb/sim_nc_suspend_seq.sv
module sim_nc_suspend_seq;
    localparam int TXL = 5;
    localparam int RXL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, stop_req = 0, init_done = 0, suspend_req = 0, fast_en = 0;
    logic tx_dma_busy = 0, rx_frame_busy = 0;
    logic tx_fifo_empty = 0, rx_fifo_empty = 0, lbm_tx_empty = 0, lbm_rx_empty = 0;
    logic tx_adv = 0, rx_adv = 0;
    logic rx_accept_en, tx_fetch_en, susp_status;
    logic [2:0] state_o;
    logic [2:0] tx_idx;
    logic [1:0] rx_idx;

    int n_chk = 0, n_fail = 0;
    int exp_tx = 0, exp_rx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nc_suspend_seq #(.TX_RING_LEN(TXL), .RX_RING_LEN(RXL)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_req(stop_req),
        .init_done(init_done), .suspend_req(suspend_req), .fast_en(fast_en),
        .tx_dma_busy(tx_dma_busy), .rx_frame_busy(rx_frame_busy),
        .tx_fifo_empty(tx_fifo_empty), .rx_fifo_empty(rx_fifo_empty),
        .lbm_tx_empty(lbm_tx_empty), .lbm_rx_empty(lbm_rx_empty),
        .tx_adv(tx_adv), .rx_adv(rx_adv), .rx_accept_en(rx_accept_en),
        .tx_fetch_en(tx_fetch_en), .susp_status(susp_status), .state_o(state_o),
        .tx_idx(tx_idx), .rx_idx(rx_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic chk_idx(input string req);
        chk({req, " tx_idx"}, int'(tx_idx), exp_tx);
        chk({req, " rx_idx"}, int'(rx_idx), exp_rx);
    endtask

    task automatic do_init();
        init_done = 1; step(); init_done = 0;
    endtask

    task automatic t_reset_init();
        repeat (3) step();
        rst_n = 1;
        chk("R1 state", int'(state_o), 0);
        chk("R1 status", int'(susp_status), 0);
        chk("R1 rx_accept", int'(rx_accept_en), 0);
        chk("R1 tx_fetch", int'(tx_fetch_en), 0);
        chk_idx("R1");
        repeat (2) step();
        chk("R1 waits init", int'(state_o), 0);
        do_init();
        chk("R1 run", int'(state_o), 1);
        chk("R1 rx_accept run", int'(rx_accept_en), 1);
        chk("R1 tx_fetch run", int'(tx_fetch_en), 1);
    endtask

    task automatic t_advance();
        tx_adv = 1; repeat (6) step(); tx_adv = 0;
        exp_tx = 6 % TXL;
        rx_adv = 1; repeat (5) step(); rx_adv = 0;
        exp_rx = 5 % RXL;
        chk_idx("R8 wrap");
    endtask

    task automatic t_slow();
        tx_dma_busy = 1; rx_frame_busy = 1;
        suspend_req = 1; step();
        chk("R2 drain_active", int'(state_o), 2);
        chk("R2 rx_accept off", int'(rx_accept_en), 0);
        chk("R2 tx_fetch off", int'(tx_fetch_en), 0);
        chk("R6 status in drain", int'(susp_status), 0);
        tx_adv = 1; step(); tx_adv = 0;
        exp_tx = (exp_tx + 1) % TXL;
        repeat (2) step();
        chk("R3 hold busy", int'(state_o), 2);
        chk_idx("R8 drain advance");
        tx_dma_busy = 0; step();
        chk("R3 hold rx busy", int'(state_o), 2);
        rx_frame_busy = 0; step();
        chk("R4 drain_buffers", int'(state_o), 3);
        chk("R6 status buffers", int'(susp_status), 0);
        tx_fifo_empty = 1; rx_fifo_empty = 1; lbm_tx_empty = 1; step();
        chk("R4 lbm rx pending", int'(state_o), 3);
        lbm_rx_empty = 1; step();
        chk("R4 suspended", int'(state_o), 4);
        chk("R6 status set", int'(susp_status), 1);
        tx_adv = 1; rx_adv = 1; step(); tx_adv = 0; rx_adv = 0; step();
        chk_idx("R8 ignored suspended");
    endtask

    task automatic t_resume();
        suspend_req = 0; step();
        chk("R7 resume run", int'(state_o), 1);
        chk("R7 status clear", int'(susp_status), 0);
        chk("R7 rx_accept", int'(rx_accept_en), 1);
        chk_idx("R7 kept");
    endtask

    task automatic t_fast();
        fast_en = 1;
        tx_fifo_empty = 0; rx_fifo_empty = 0; lbm_tx_empty = 0; lbm_rx_empty = 0;
        suspend_req = 1; step();
        chk("R5 drain_active", int'(state_o), 2);
        step();
        chk("R5 direct suspend", int'(state_o), 4);
        chk("R5 status", int'(susp_status), 1);
        suspend_req = 0; step();
        chk("R7 fast resume", int'(state_o), 1);
        fast_en = 0;
    endtask

    task automatic t_abort();
        tx_dma_busy = 1; suspend_req = 1; step();
        chk("R7 abort a", int'(state_o), 2);
        suspend_req = 0; step();
        chk("R7 abort a run", int'(state_o), 1);
        tx_dma_busy = 0;
        suspend_req = 1; repeat (2) step();
        chk("R7 abort b", int'(state_o), 3);
        suspend_req = 0; step();
        chk("R7 abort b run", int'(state_o), 1);
        chk_idx("R7 abort kept");
    endtask

    task automatic t_stop();
        tx_fifo_empty = 1; rx_fifo_empty = 1; lbm_tx_empty = 1; lbm_rx_empty = 1;
        suspend_req = 1; repeat (3) step();
        chk("R9 pre suspended", int'(state_o), 4);
        stop_req = 1; step(); stop_req = 0;
        exp_tx = 0; exp_rx = 0;
        chk("R9 stopped", int'(state_o), 0);
        chk_idx("R9 stop clear");
        suspend_req = 0; repeat (3) step();
        chk("R9 needs init", int'(state_o), 0);
        do_init();
        chk("R9 reinit", int'(state_o), 1);
        tx_adv = 1; repeat (3) step(); tx_adv = 0;
        soft_rst = 1; step(); soft_rst = 0;
        chk("R9 soft stopped", int'(state_o), 0);
        chk_idx("R9 soft clear");
        do_init();
    endtask

    task automatic t_hard();
        tx_adv = 1; rx_adv = 1; repeat (2) step(); tx_adv = 0; rx_adv = 0;
        exp_tx = 2; exp_rx = 2;
        chk_idx("R8 pre hard");
        rst_n = 0; step();
        exp_tx = 0; exp_rx = 0;
        chk("R10 state", int'(state_o), 0);
        chk_idx("R10");
        rst_n = 1; step();
        chk("R10 stays stopped", int'(state_o), 0);
    endtask

    initial begin
        t_reset_init();
        t_advance();
        t_slow();
        t_resume();
        t_fast();
        t_abort();
        t_stop();
        t_hard();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule